// File: doc/BRIEF.md
# Block Transfer Address Sequencer

This block turns one multi-register load or store instruction into a run of single-word transfers. A one-cycle start pulse captures a 32-bit instruction word and the current value of its base register. The block decodes the direction, the before/after choice, writeback and load/store bits. It counts the registers selected in the 16-bit register list and works out the lowest word address of the block. It then issues one transfer per accepted handshake to a memory port. Each transfer carries a register index, a word address and a load flag.

Registers are always visited lowest index first at rising word addresses, whatever the direction bit says. The direction only moves the block below or above the base. When the last transfer has been accepted, the block raises a one-cycle done pulse. In the same cycle it presents the updated base value, an enable that is high only when the instruction asks for writeback, and the base register number. An instruction with an empty register list, or one that does not belong to this class, produces a one-cycle error pulse instead, with no transfers.

Top module: `blk_xfer_seq`

## Requirements
- R1: The instruction class field, bits [27:25], must equal 3'b100. Bit 20 is the load flag (1 = load, 0 = store), and `xfer_load_o` carries it on every transfer of the sequence.
- R2: If at start the class field is wrong or the register list (bits [15:0]) is all zero, `err_o` is high for exactly the one cycle after start. No transfer, no done pulse and no writeback follow.
- R3: One transfer is issued for each set bit of the list, where bit i selects register i. The indices come out in strictly ascending order.
- R4: Each accepted transfer raises the next transfer's address by 4.
- R5: With n set list bits, U = bit 23 and P = bit 24, the first address is: base (U=1,P=0); base+4 (U=1,P=1); base-4n+4 (U=0,P=0); base-4n (U=0,P=1).
- R6: `done_o` is high for exactly the one cycle after the last accepted transfer. In that cycle `wb_en_o` equals bit 21 and `wb_reg_o` equals bits [19:16]. When writeback is enabled, `wb_val_o` is base+4n if U=1 and base-4n if U=0.
- R7: While `xfer_valid_o` is high and `xfer_ready_i` is low, the index, address and load flag hold their values into the next cycle.
- R8: A start pulse that arrives while the block is busy, including the done cycle, is ignored. No new sequence begins.
- R9: The base and instruction are captured at start. Changes on `base_i` or `instr_i` during the sequence do not affect any address or writeback value.
- R10: After reset the block is idle, with valid, done, error, writeback enable and busy all low.
- R11: An accepted start on a legal instruction raises `xfer_valid_o` in the very next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Start pulse, taken only when idle |
| instr_i | input | 32 | Instruction word |
| base_i | input | 32 | Current base register value |
| busy_o | output | 1 | Sequence, done or error cycle in progress |
| err_o | output | 1 | One-cycle illegal-instruction pulse |
| xfer_valid_o | output | 1 | Transfer request valid |
| xfer_ready_i | input | 1 | Memory port accepts the transfer |
| xfer_reg_o | output | 4 | Register index of the transfer |
| xfer_addr_o | output | 32 | Word address of the transfer |
| xfer_load_o | output | 1 | 1 = load, 0 = store |
| done_o | output | 1 | One-cycle end-of-sequence pulse |
| wb_en_o | output | 1 | Base writeback enable, only with done |
| wb_reg_o | output | 4 | Base register number |
| wb_val_o | output | 32 | Updated base value |

## Verification
The assertions check several properties on every cycle: that a stalled transfer holds its fields, that the address steps by one word and the index rises across each handshake, and that done and error are single pulses which never overlap a transfer. They also check that writeback enable appears only with done and that a legal start produces a transfer in the next cycle. Only the bench scenarios can show that the first address and the writeback value match the four submode formulas for a given population count. The same holds for showing that every set list bit is visited exactly once, that base or start changes during a run are ignored, and that an empty list or wrong class yields an error with no traffic.

// File: rtl/bxs_pkg.sv
package bxs_pkg;

   // Instruction field positions; the sequencer's behaviour depends on these.
   localparam int unsigned CLS_HI  = 27;
   localparam int unsigned CLS_LO  = 25;
   localparam logic [2:0]  CLS_VAL = 3'b100;
   localparam int unsigned P_BIT   = 24;
   localparam int unsigned U_BIT   = 23;
   localparam int unsigned W_BIT   = 21;
   localparam int unsigned L_BIT   = 20;
   localparam int unsigned BR_HI   = 19;
   localparam int unsigned BR_LO   = 16;

   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_RUN  = 2'd1,
      ST_DONE = 2'd2,
      ST_ERR  = 2'd3
   } seq_st_e;

   // Encoded as {U, P}
   typedef enum logic [1:0] {
      SM_DEC_AFT = 2'b00,
      SM_DEC_BEF = 2'b01,
      SM_INC_AFT = 2'b10,
      SM_INC_BEF = 2'b11
   } walk_mode_e;

endpackage

// File: rtl/bxs_popcnt.sv
module bxs_popcnt #(
   parameter int unsigned W     = 16,
   localparam int unsigned CNT_W = $clog2(W + 1)
) (
   input  logic [W-1:0]     vec_i,
   output logic [CNT_W-1:0] cnt_o
);

   logic [CNT_W-1:0] part [0:W];

   assign part[0] = '0;

   for (genvar g = 0; g < W; g++) begin : g_sum
      assign part[g+1] = part[g] + CNT_W'(vec_i[g]);
   end

   assign cnt_o = part[W];

endmodule

// File: rtl/bxs_lowbit.sv
module bxs_lowbit #(
   parameter int unsigned W     = 16,
   parameter int unsigned STYLE = 0,
   localparam int unsigned IDX_W = $clog2(W)
) (
   input  logic [W-1:0]     vec_i,
   output logic [IDX_W-1:0] idx_o
);

   if (STYLE == 0) begin : g_scan
      // Downward scan: the last hit written is the lowest set bit.
      always_comb begin
         idx_o = '0;
         for (int i = W - 1; i >= 0; i--) begin
            if (vec_i[i]) idx_o = IDX_W'(i);
         end
      end
   end else begin : g_isolate
      // Isolate lowest set bit as a one-hot word, then OR-encode it.
      logic [W-1:0] onehot;
      assign onehot = vec_i & (~vec_i + W'(1));
      always_comb begin
         idx_o = '0;
         for (int i = 0; i < W; i++) begin
            if (onehot[i]) idx_o = idx_o | IDX_W'(i);
         end
      end
   end

endmodule

// File: rtl/bxs_decode.sv
module bxs_decode
   import bxs_pkg::*;
#(
   parameter int unsigned ADDR_W     = 32,
   parameter int unsigned NREG       = 16,
   parameter int unsigned WORD_BYTES = 4,
   localparam int unsigned CNT_W     = $clog2(NREG + 1),
   localparam int unsigned WSH       = $clog2(WORD_BYTES)
) (
   input  logic [31:0]       instr_i,
   input  logic [ADDR_W-1:0] base_i,
   output logic              legal_o,
   output logic [NREG-1:0]   list_o,
   output logic              load_o,
   output logic              wb_o,
   output logic [3:0]        wb_reg_o,
   output logic [ADDR_W-1:0] first_o,
   output logic [ADDR_W-1:0] wb_val_o
);

   logic [CNT_W-1:0]  cnt;
   logic [ADDR_W-1:0] span;
   logic [ADDR_W-1:0] step;
   walk_mode_e        mode;

   assign list_o   = instr_i[NREG-1:0];
   assign load_o   = instr_i[L_BIT];
   assign wb_o     = instr_i[W_BIT];
   assign wb_reg_o = instr_i[BR_HI:BR_LO];
   assign mode     = walk_mode_e'({instr_i[U_BIT], instr_i[P_BIT]});

   bxs_popcnt #(.W(NREG)) u_cnt (
      .vec_i (list_o),
      .cnt_o (cnt)
   );

   assign legal_o = (instr_i[CLS_HI:CLS_LO] == CLS_VAL) && (cnt != '0);
   assign span    = ADDR_W'(cnt) << WSH;
   assign step    = ADDR_W'(WORD_BYTES);

   always_comb begin
      unique case (mode)
         SM_INC_AFT: first_o = base_i;
         SM_INC_BEF: first_o = base_i + step;
         SM_DEC_AFT: first_o = base_i - span + step;
         default:    first_o = base_i - span;
      endcase
   end

   assign wb_val_o = instr_i[U_BIT] ? (base_i + span) : (base_i - span);

endmodule

// File: rtl/blk_xfer_seq.sv
module blk_xfer_seq
   import bxs_pkg::*;
#(
   parameter int unsigned ADDR_W       = 32,
   parameter int unsigned NREG         = 16,
   parameter int unsigned WORD_BYTES   = 4,
   parameter int unsigned LOWBIT_STYLE = 1,
   localparam int unsigned IDX_W       = $clog2(NREG)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   input  logic [31:0]       instr_i,
   input  logic [ADDR_W-1:0] base_i,
   output logic              busy_o,
   output logic              err_o,
   output logic              xfer_valid_o,
   input  logic              xfer_ready_i,
   output logic [IDX_W-1:0]  xfer_reg_o,
   output logic [ADDR_W-1:0] xfer_addr_o,
   output logic              xfer_load_o,
   output logic              done_o,
   output logic              wb_en_o,
   output logic [3:0]        wb_reg_o,
   output logic [ADDR_W-1:0] wb_val_o
);

   if (NREG < 2 || NREG > 16) begin : g_bad_nreg
      $error("blk_xfer_seq: NREG must lie in 2..16");
   end
   if (WORD_BYTES == 0 || (WORD_BYTES & (WORD_BYTES - 1)) != 0) begin : g_bad_word
      $error("blk_xfer_seq: WORD_BYTES must be a power of two");
   end
   if (ADDR_W < 8) begin : g_bad_addr
      $error("blk_xfer_seq: ADDR_W too narrow");
   end

   seq_st_e           st_q;
   logic [NREG-1:0]   mask_q;
   logic [ADDR_W-1:0] addr_q;
   logic              load_q;
   logic              wb_q;
   logic [3:0]        wbr_q;
   logic [ADDR_W-1:0] wbv_q;

   logic              d_legal;
   logic [NREG-1:0]   d_list;
   logic              d_load;
   logic              d_wb;
   logic [3:0]        d_wbr;
   logic [ADDR_W-1:0] d_first;
   logic [ADDR_W-1:0] d_wbv;

   logic              fire;
   logic              last;
   logic [NREG-1:0]   mask_nx;

   bxs_decode #(
      .ADDR_W     (ADDR_W),
      .NREG       (NREG),
      .WORD_BYTES (WORD_BYTES)
   ) u_dec (
      .instr_i  (instr_i),
      .base_i   (base_i),
      .legal_o  (d_legal),
      .list_o   (d_list),
      .load_o   (d_load),
      .wb_o     (d_wb),
      .wb_reg_o (d_wbr),
      .first_o  (d_first),
      .wb_val_o (d_wbv)
   );

   bxs_lowbit #(
      .W     (NREG),
      .STYLE (LOWBIT_STYLE)
   ) u_low (
      .vec_i (mask_q),
      .idx_o (xfer_reg_o)
   );

   assign fire    = (st_q == ST_RUN) && xfer_ready_i;
   assign mask_nx = mask_q & (mask_q - NREG'(1));
   assign last    = (mask_nx == '0);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q   <= ST_IDLE;
         mask_q <= '0;
         addr_q <= '0;
         load_q <= 1'b0;
         wb_q   <= 1'b0;
         wbr_q  <= '0;
         wbv_q  <= '0;
      end else begin
         unique case (st_q)
            ST_IDLE: begin
               if (start_i) begin
                  if (d_legal) begin
                     st_q   <= ST_RUN;
                     mask_q <= d_list;
                     addr_q <= d_first;
                     load_q <= d_load;
                     wb_q   <= d_wb;
                     wbr_q  <= d_wbr;
                     wbv_q  <= d_wbv;
                  end else begin
                     st_q <= ST_ERR;
                  end
               end
            end
            ST_RUN: begin
               if (fire) begin
                  mask_q <= mask_nx;
                  addr_q <= addr_q + ADDR_W'(WORD_BYTES);
                  if (last) st_q <= ST_DONE;
               end
            end
            default: st_q <= ST_IDLE;
         endcase
      end
   end

   assign busy_o       = (st_q != ST_IDLE);
   assign err_o        = (st_q == ST_ERR);
   assign xfer_valid_o = (st_q == ST_RUN);
   assign xfer_addr_o  = addr_q;
   assign xfer_load_o  = load_q;
   assign done_o       = (st_q == ST_DONE);
   assign wb_en_o      = (st_q == ST_DONE) && wb_q;
   assign wb_reg_o     = wbr_q;
   assign wb_val_o     = wbv_q;

endmodule

// File: rtl/bxs_chk.sv
module bxs_chk #(
   parameter int unsigned ADDR_W     = 32,
   parameter int unsigned NREG       = 16,
   parameter int unsigned WORD_BYTES = 4,
   localparam int unsigned IDX_W     = $clog2(NREG)
) (
   input logic              clk,
   input logic              rst_n,
   input logic              start_i,
   input logic              busy_o,
   input logic              err_o,
   input logic              xfer_valid_o,
   input logic              xfer_ready_i,
   input logic [IDX_W-1:0]  xfer_reg_o,
   input logic [ADDR_W-1:0] xfer_addr_o,
   input logic              xfer_load_o,
   input logic              done_o,
   input logic              wb_en_o
);

   p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (xfer_valid_o && !xfer_ready_i) |=>
         (xfer_valid_o && $stable(xfer_addr_o) && $stable(xfer_reg_o) && $stable(xfer_load_o)));

   p_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (xfer_valid_o && xfer_ready_i) |=>
         (!xfer_valid_o || (xfer_addr_o == $past(xfer_addr_o) + ADDR_W'(WORD_BYTES))));

   p_order_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (xfer_valid_o && xfer_ready_i) |=> (!xfer_valid_o || (xfer_reg_o > $past(xfer_reg_o))));

   p_load_const_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (xfer_valid_o && $past(xfer_valid_o)) |-> $stable(xfer_load_o));

   p_done_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o);

   p_done_after_xfer_r6: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> $past(xfer_valid_o && xfer_ready_i));

   p_wb_with_done_r6: assert property (@(posedge clk) disable iff (!rst_n)
      wb_en_o |-> done_o);

   p_err_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
      err_o |-> (!xfer_valid_o && !done_o && !wb_en_o));

   p_err_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
      err_o |=> !err_o);

   p_idle_after_done_r8: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !busy_o);

   p_launch_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy_o && start_i) |=> (xfer_valid_o || err_o));

endmodule

bind blk_xfer_seq bxs_chk #(
   .ADDR_W     (ADDR_W),
   .NREG       (NREG),
   .WORD_BYTES (WORD_BYTES)
) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .start_i      (start_i),
   .busy_o       (busy_o),
   .err_o        (err_o),
   .xfer_valid_o (xfer_valid_o),
   .xfer_ready_i (xfer_ready_i),
   .xfer_reg_o   (xfer_reg_o),
   .xfer_addr_o  (xfer_addr_o),
   .xfer_load_o  (xfer_load_o),
   .done_o       (done_o),
   .wb_en_o      (wb_en_o)
);

// File: tb/blk_xfer_seq_tb.sv
`timescale 1ns/1ps
module blk_xfer_seq_tb;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start_i = 1'b0;
   logic [31:0] instr_i = '0;
   logic [31:0] base_i = '0;
   logic        busy_o, err_o, xfer_valid_o, xfer_load_o, done_o, wb_en_o;
   logic        xfer_ready_i = 1'b0;
   logic [3:0]  xfer_reg_o, wb_reg_o;
   logic [31:0] xfer_addr_o, wb_val_o;

   int total = 0;
   int bad = 0;
   int cyc = 0;

   always #4 clk = ~clk;

   blk_xfer_seq u_dut (
      .clk          (clk),
      .rst_n        (rst_n),
      .start_i      (start_i),
      .instr_i      (instr_i),
      .base_i       (base_i),
      .busy_o       (busy_o),
      .err_o        (err_o),
      .xfer_valid_o (xfer_valid_o),
      .xfer_ready_i (xfer_ready_i),
      .xfer_reg_o   (xfer_reg_o),
      .xfer_addr_o  (xfer_addr_o),
      .xfer_load_o  (xfer_load_o),
      .done_o       (done_o),
      .wb_en_o      (wb_en_o),
      .wb_reg_o     (wb_reg_o),
      .wb_val_o     (wb_val_o)
   );

   always @(posedge clk) begin
      cyc <= cyc + 1;
      if (cyc > 150000) begin
         bad = bad + 1;
         total = total + 1;
         $display("FAIL watchdog act=%0d exp=<150000", cyc);
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s act=%h exp=%h", tag, act, exp);
      end
   endtask

   function automatic int popc(input logic [15:0] m);
      int c = 0;
      for (int i = 0; i < 16; i++) c += int'(m[i]);
      return c;
   endfunction

   function automatic logic [31:0] first_addr(input logic [31:0] ins, input logic [31:0] b);
      logic [31:0] s = 32'(popc(ins[15:0]) * 4);
      if (ins[23]) return ins[24] ? b + 32'd4 : b;
      else         return ins[24] ? b - s : b - s + 32'd4;
   endfunction

   function automatic logic [31:0] wb_value(input logic [31:0] ins, input logic [31:0] b);
      logic [31:0] s = 32'(popc(ins[15:0]) * 4);
      return ins[23] ? b + s : b - s;
   endfunction

   task automatic run_seq(input logic [31:0] ins, input logic [31:0] b, input int rdy_pct, input bit poke);
      logic [15:0] rem;
      logic [31:0] a;
      int          idx;
      bit          illegal, r, stalled;
      illegal = (ins[27:25] != 3'b100) || (ins[15:0] == 16'h0);
      @(negedge clk);
      start_i = 1'b1; instr_i = ins; base_i = b;
      @(negedge clk);
      start_i = 1'b0;
      base_i  = $urandom;   // R9: must not matter after capture
      instr_i = $urandom;
      if (illegal) begin
         chk(err_o == 1'b1, "R2 err pulse", 32'(err_o), 32'd1);
         chk(xfer_valid_o == 1'b0, "R2 no xfer", 32'(xfer_valid_o), 32'd0);
         @(negedge clk);
         chk(err_o == 1'b0 && xfer_valid_o == 1'b0 && done_o == 1'b0, "R2 one cycle quiet",
             {err_o, xfer_valid_o, done_o}, 32'd0);
         return;
      end
      rem = ins[15:0];
      a = first_addr(ins, b);
      stalled = 1'b0;
      for (int k = 0; rem != 16'h0; ) begin
         idx = 0;
         for (int i = 15; i >= 0; i--) if (rem[i]) idx = i;
         chk(xfer_valid_o == 1'b1, "R11 valid", 32'(xfer_valid_o), 32'd1);
         chk(xfer_reg_o == 4'(idx), stalled ? "R7 hold reg" : "R3 reg order", 32'(xfer_reg_o), 32'(idx));
         chk(xfer_addr_o == a, (k == 0) ? "R5 first addr" : (stalled ? "R7 hold addr" : "R4 addr step"),
             xfer_addr_o, a);
         chk(xfer_load_o == ins[20], "R1 load flag", 32'(xfer_load_o), 32'(ins[20]));
         chk(done_o == 1'b0, "R6 no early done", 32'(done_o), 32'd0);
         start_i = poke && (($urandom % 3) == 0);   // R8: ignored while busy
         r = (($urandom % 100) < rdy_pct);
         xfer_ready_i = r;
         stalled = !r;
         if (r) begin
            k++;
            a = a + 32'd4;
            rem = rem & (rem - 16'd1);
         end
         @(negedge clk);
      end
      start_i = poke;   // R8: start during the done cycle
      chk(done_o == 1'b1, "R6 done", 32'(done_o), 32'd1);
      chk(xfer_valid_o == 1'b0, "R3 count", 32'(xfer_valid_o), 32'd0);
      chk(wb_en_o == ins[21], "R6 wb enable", 32'(wb_en_o), 32'(ins[21]));
      if (ins[21]) begin
         chk(wb_val_o == wb_value(ins, b), "R6 wb value", wb_val_o, wb_value(ins, b));
         chk(wb_reg_o == ins[19:16], "R6 wb reg", 32'(wb_reg_o), 32'(ins[19:16]));
      end
      @(negedge clk);
      start_i = 1'b0;
      chk(done_o == 1'b0, "R6 done one cycle", 32'(done_o), 32'd0);
      chk(busy_o == 1'b0 && xfer_valid_o == 1'b0, "R8 start ignored", {busy_o, xfer_valid_o}, 32'd0);
   endtask

   function automatic logic [31:0] mk(input bit u, input bit p, input bit w, input bit l,
                                       input logic [3:0] br, input logic [15:0] lst);
      return {4'hE, 3'b100, p, u, 1'b0, w, l, br, lst};
   endfunction

   initial begin
      void'($urandom(32'd20240611));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R10 reset state
      chk({busy_o, err_o, xfer_valid_o, done_o, wb_en_o} == 5'b0, "R10 reset idle",
          {busy_o, err_o, xfer_valid_o, done_o, wb_en_o}, 32'd0);
      // R5 each submode, mixed lists
      run_seq(mk(1, 0, 1, 1, 4'd13, 16'h00F0), 32'h0000_1000, 100, 0);
      run_seq(mk(1, 1, 1, 0, 4'd2,  16'h8001), 32'h0000_2000, 100, 0);
      run_seq(mk(0, 0, 1, 1, 4'd7,  16'hFFFF), 32'h0000_3000, 60, 0);
      run_seq(mk(0, 1, 1, 0, 4'd0,  16'h0A50), 32'h0000_0008, 100, 0);
      // single register R15, no writeback
      run_seq(mk(0, 1, 0, 1, 4'd5,  16'h8000), 32'h0000_4000, 100, 0);
      // R7 heavy stalls, R8 spurious starts
      run_seq(mk(1, 0, 1, 0, 4'd9,  16'h1234), 32'hFFFF_FFF0, 25, 1);
      // R2 empty list and wrong class
      run_seq(mk(1, 0, 1, 1, 4'd1,  16'h0000), 32'h0000_5000, 100, 0);
      run_seq(mk(1, 0, 1, 1, 4'd1,  16'h0003) ^ 32'h0200_0000, 32'h0000_5000, 100, 0);
      // random mix
      for (int t = 0; t < 60; t++) begin
         logic [31:0] ins;
         ins = $urandom;
         if (($urandom % 12) != 0) ins[27:25] = 3'b100;
         if (($urandom % 10) == 0) ins[15:0] = 16'h0;
         else if (($urandom % 2) == 0) ins[15:0] = ins[15:0] & 16'($urandom);
         run_seq(ins, $urandom, 30 + int'($urandom % 71), bit'($urandom % 2));
      end
      repeat (2) @(negedge clk);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule